// File: doc/BRIEF.md
# AND-merge byte programmer

This block controls the programming of single bytes in a small non-volatile array that behaves like flash: programming can clear bits but cannot set them. The array holds 256 bytes and is modelled inside the block as a register array. After reset every byte is in the erased state 0xFF.

A host uses a simple register bus. It writes a target byte address and a data byte, then writes a program command. The controller reads the addressed byte and ANDs it with the data byte. It writes the result back to the same location and then pulses a completion flag. While an operation is in progress a busy flag is high. During that time the bus cannot change the target address or the data byte, and a new command is not accepted.

A separate read port with one cycle of latency lets the host inspect any byte of the array.

Top module: `fbyte_prog`

## Requirements
- R1: After reset, `busy` and `done` are 0, the target-address register and the data register both read 0x00, and every array byte reads 0xFF.
- R2: A bus write to register address 0x70 loads the target-address register. A bus write to 0x6F loads the data register. Both registers read back on `reg_rdata` combinationally at the same addresses. Any other address reads 0x00.
- R3: Writing 0x0F to the command register at address 0x71 while idle starts an operation. `busy` is high for exactly the two cycles that follow the accepting clock edge: one read cycle, then one write cycle.
- R4: When an operation completes, the byte at the target address holds the bitwise AND of its previous value and the data register. A bit is never set by programming.
- R5: Each operation changes only the byte at the target address. All other bytes keep their values.
- R6: Writing any value other than 0x0F to the command register starts nothing and changes no byte.
- R7: While `busy` is high, command writes are dropped and writes to 0x70 or 0x6F are ignored.
- R8: Both registers keep their values after an operation. Repeating the command with the same contents leaves the byte unchanged.
- R9: `done` is high for exactly one cycle: the first cycle after `busy` falls at the end of an operation.
- R10: `mem_rdata` shows the array byte at `mem_raddr` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when write-back has finished |
| mem_raddr | input | 8 | Array read address |
| mem_rdata | output | 8 | Array read data, one cycle latency |

## Verification
On every cycle, the assertions check the following:
- the write-back value never has a bit set that the stored byte lacks;
- an accepted command raises `busy` for exactly two cycles;
- `done` is a single-cycle pulse that follows `busy`;
- the target and data registers stay frozen while `busy` is high.

Some behaviour only the bench scenarios can show. That includes the resulting contents of the array, compared against a model of the bytes. It also includes the neighbouring bytes being left alone, non-program command values and dropped commands having no effect, and idempotent repeats. The scoreboard checks that each accepted command produces exactly one `done` in the expected cycle.

// File: rtl/fbyte_prog.sv
module fbyte_prog #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter logic [7:0] A_TGT  = 8'h70,
  parameter logic [7:0] A_DAT  = 8'h6F,
  parameter logic [7:0] A_CMD  = 8'h71,
  parameter logic [7:0] CMD_GO = 8'h0F,
  parameter logic [DW-1:0] ERASED = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          done,
  input  logic [AW-1:0] mem_raddr,
  output logic [DW-1:0] mem_rdata
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} st_t;

  st_t           st;
  logic [AW-1:0] tgt;
  logic [DW-1:0] dat;
  logic [DW-1:0] merged;
  logic [DW-1:0] mem [DEPTH];

  wire idle   = (st == S_IDLE);
  wire go     = reg_we && idle && reg_addr == A_CMD && reg_wdata == CMD_GO;
  wire tgt_we = reg_we && idle && reg_addr == A_TGT;
  wire dat_we = reg_we && idle && reg_addr == A_DAT;
  wire wr_en  = (st == S_WRITE);

  assign busy = !idle;

  always_comb begin
    if (reg_addr == A_TGT)      reg_rdata = DW'(tgt);
    else if (reg_addr == A_DAT) reg_rdata = dat;
    else                        reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tgt    <= '0;
      dat    <= '0;
      merged <= '0;
      done   <= 1'b0;
    end else begin
      done <= wr_en;
      if (tgt_we) tgt <= reg_wdata[AW-1:0];
      if (dat_we) dat <= reg_wdata;
      case (st)
        S_IDLE:  if (go) st <= S_READ;
        S_READ:  begin merged <= mem[tgt] & dat; st <= S_WRITE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      mem_rdata <= ERASED;
    end else begin
      mem_rdata <= mem[mem_raddr];
      if (wr_en) mem[tgt] <= merged;
    end
  end

  AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((merged & ~mem[tgt]) == '0)); // R4

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R3

  AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R3

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_TGT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt)); // R7

  AST_DAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dat)); // R7
endmodule

// File: tb/fbyte_prog_test.sv
module fbyte_prog_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       busy, done;
  logic [7:0] mem_raddr = 0;
  logic [7:0] mem_rdata;

  fbyte_prog uut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int expq[$];
  logic [7:0] model [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) chk("R7 unexpected done", 1, 0);
      else chk("R9 done cycle", cyc, expq.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rdreg(input string req, input logic [7:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, e);
  endtask

  task automatic rdmem(input string req, input logic [7:0] a);
    @(negedge clk);
    mem_raddr = a;
    @(negedge clk);
    chk(req, mem_rdata, model[a]);
  endtask

  task automatic program_op(input logic [7:0] a, input logic [7:0] d);
    wr(8'h70, a);
    wr(8'h6F, d);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h71; reg_wdata = 8'h0F;
    expq.push_back(cyc + 3);
    model[a] = model[a] & d;
    @(negedge clk); reg_we = 0;
    chk("R3 busy first", busy, 1);
    @(negedge clk); chk("R3 busy second", busy, 1);
    @(negedge clk); chk("R3 busy fall", busy, 0);
    chk("R9 done high", done, 1);
    @(negedge clk); chk("R9 done low", done, 0);
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rdreg("R1 tgt", 8'h70, 8'h00);
    rdreg("R1 dat", 8'h6F, 8'h00);
    rdmem("R1 erased", 8'h00);
    rdmem("R1 erased", 8'hFF);

    wr(8'h70, 8'h12);
    wr(8'h6F, 8'hA5);
    rdreg("R2 tgt", 8'h70, 8'h12);
    rdreg("R2 dat", 8'h6F, 8'hA5);
    rdreg("R2 other", 8'h55, 8'h00);

    program_op(8'h12, 8'hA5);
    rdmem("R4 first", 8'h12);
    rdmem("R5 below", 8'h11);
    rdmem("R5 above", 8'h13);
    program_op(8'h12, 8'h3C);
    rdmem("R4 merge no set", 8'h12);
    program_op(8'h00, 8'h00);
    rdmem("R4 addr zero", 8'h00);
    program_op(8'hFF, 8'h7E);
    rdmem("R4 addr top", 8'hFF);
    rdmem("R5 neighbor", 8'hFE);

    rdreg("R8 tgt kept", 8'h70, 8'hFF);
    rdreg("R8 dat kept", 8'h6F, 8'h7E);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h71; reg_wdata = 8'h0F;
    expq.push_back(cyc + 3);
    @(negedge clk); reg_we = 0;
    repeat (4) @(negedge clk);
    rdmem("R8 repeat unchanged", 8'hFF);

    wr(8'h70, 8'h40);
    wr(8'h6F, 8'h00);
    wr(8'h71, 8'h0E);
    wr(8'h71, 8'hF0);
    @(negedge clk);
    chk("R6 no busy", busy, 0);
    rdmem("R6 byte kept", 8'h40);

    wr(8'h70, 8'h50);
    wr(8'h6F, 8'h0F);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h71; reg_wdata = 8'h0F;
    expq.push_back(cyc + 3);
    model[8'h50] = 8'h0F;
    @(negedge clk); reg_addr = 8'h71; reg_wdata = 8'h0F;
    @(negedge clk); reg_addr = 8'h70; reg_wdata = 8'h60;
    @(negedge clk); reg_we = 0;
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h6F; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 0;
    rdreg("R7 tgt unchanged", 8'h70, 8'h50);
    rdreg("R7 dat changed after idle", 8'h6F, 8'h00);
    repeat (3) @(negedge clk);
    rdmem("R7 target once", 8'h50);
    rdmem("R7 other untouched", 8'h60);

    mem_raddr = 8'h12;
    @(negedge clk);
    mem_raddr = 8'h40;
    #1 chk("R10 latency old", mem_rdata, model[8'h12]);
    @(negedge clk);
    chk("R10 latency new", mem_rdata, model[8'h40]);

    repeat (4) @(negedge clk);
    chk("R9 all done seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule